// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and drives a 4-bit interrupt level to each of up to sixteen processors. Software programs it over a simple 32-bit register bus.

- **Per-processor state:** each processor has its own mask register and force register.
- **Shared state:** all processors share one pending register, one priority-class register and one broadcast register.
- **Broadcast:** a line marked for broadcast is posted into every processor's force register. It is not posted into the shared pending register.
- **Acknowledge:** each processor has its own acknowledge port. An acknowledge clears the processor's own force bit when that bit is set. Otherwise it clears the shared pending bit.

A multiprocessor status register reports:
- the processor count,
- whether broadcast is available,
- which processors are halted.

Writing ones to the status register starts the matching processors. Each processor also has a power-down input that halts it. A nonzero interrupt level for a processor wakes that processor. The controller drives a run output per processor.

Top module: `mp_irq_ctrl`

## Requirements
- R1: For processor c, the request vector is (pending OR force[c]) AND mask[c]. Only that vector feeds processor c's level output.
- R2: A requested line whose bit is set in the priority-class register (offset 0x00) always beats any requested line whose class bit is clear.
- R3: Within one class, the highest-numbered requested line wins, and the level output is 0 when nothing is requested. The output is registered and reflects a state change on the second clock edge after the input that caused it.
- R4: A rising edge on request line n sets pending bit n once. A line held high does not set the bit again after it has been acknowledged.
- R5: When NCPU > 1 and broadcast bit n (offset 0x14) is set, a rising edge on line n sets bit n in every processor's force register (offset 0x80 + 4*c). Pending bit n is left untouched.
- R6: An acknowledge of number n from processor c clears force[c] bit n if it is set; otherwise it clears pending bit n. The force registers of other processors are unaffected.
- R7: When an acknowledge and a rising edge hit the same line in the same cycle, the bit stays set.
- R8: Writes to the class register keep bits 15:1, and bit 0 reads 0. A write of ones to the clear register (offset 0x0C) clears those pending bits. The clear register and the window at 0xC0 read 0.
- R9: The status register (offset 0x10) reads as follows:
  - bits 31:28: NCPU-1;
  - bit 27: set when NCPU > 1;
  - bits 19:16: 0;
  - bit i: set while processor i is halted.
- R10: Writing 1 to status bit i starts processor i. Writing 0 has no effect.
- R11: After reset, processor 0 runs and all other processors are halted. A power-down pulse halts a processor. A nonzero level output releases the processor one cycle later.
- R12: Pending is at offset 0x04 and masks are at 0x40 + 4*c. Read data appears on the edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the 256-byte block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | input | 16 | Request lines; bit 0 ignored |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NCPU | Per-processor acknowledged line number |
| pdown_req | input | NCPU | Per-processor power-down pulse |
| cpu_level | output | 4*NCPU | Per-processor interrupt level |
| cpu_run | output | NCPU | Per-processor running flag |

## Verification
Two functions can fall in the same cycle: acknowledge handling and request posting.

- **Acknowledge plus new edge:** the bench raises line 3 on the same clock edge on which processor 0 acknowledges 3. It then reads the pending register and expects the bit still set.
- **Acknowledge alone:** the same line acknowledged without a new edge must clear the bit.
- **Broadcast:** for a broadcast line, an acknowledge from one processor must clear only that processor's force bit. Reading another processor's force register shows its copy still pending.

// File: rtl/mp_irq_pkg.sv
`timescale 1ns/1ps
package mp_irq_pkg;
  localparam int NLINE = 16;
  localparam int LVLW  = 4;
  typedef logic [NLINE-1:0] irq_vec_t;
  localparam irq_vec_t LINE_MASK = 16'hFFFE;

  localparam logic [7:0] OFF_CLASS = 8'h00;
  localparam logic [7:0] OFF_PEND  = 8'h04;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_BCAST = 8'h14;
  localparam logic [1:0] WIN_MASK  = 2'b01;
  localparam logic [1:0] WIN_FORCE = 2'b10;
endpackage

// File: rtl/mpirq_edge.sv
`timescale 1ns/1ps
module mpirq_edge #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_in;
  end

  assign rise_o = lvl_in & ~prev_q;

  // R4: a line seen rising cannot rise again on the next cycle
  p_rise_once_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/mpirq_prio.sv
`timescale 1ns/1ps
module mpirq_prio #(
  parameter int W  = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  req,
  input  logic [W-1:0]  cls1,
  output logic [LW-1:0] lvl_o
);
  function automatic logic [LW-1:0] top_idx(input logic [W-1:0] v);
    top_idx = '0;
    for (int i = 1; i < W; i++)
      if (v[i]) top_idx = LW'(i);
  endfunction

  logic [LW-1:0] hi1, hi0;
  assign hi1 = top_idx(req & cls1);
  assign hi0 = top_idx(req & ~cls1);

  always_ff @(posedge clk) begin
    if (rst) lvl_o <= '0;
    else     lvl_o <= (hi1 != '0) ? hi1 : hi0;
  end

  logic [W-1:0] sel1_q;
  always_ff @(posedge clk) begin
    if (rst) sel1_q <= '0;
    else     sel1_q <= req & cls1;
  end

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> (lvl_o == '0));

  p_cls1_wins_r2: assert property (@(posedge clk) disable iff (rst)
    ((sel1_q & ~W'(1)) != '0) |-> sel1_q[lvl_o]);
endmodule

// File: rtl/mpirq_halt.sv
`timescale 1ns/1ps
module mpirq_halt #(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCPU-1:0] pdown,
  input  logic            start_we,
  input  logic [NCPU-1:0] start_bits,
  input  logic [NCPU-1:0] busy,
  output logic [NCPU-1:0] halted_o
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam logic RST_HALT = (c != 0);
    logic go;
    assign go = (start_we && start_bits[c]) || busy[c];

    always_ff @(posedge clk) begin
      if (rst)        halted_o[c] <= RST_HALT;
      else if (go)    halted_o[c] <= 1'b0;
      else if (pdown[c]) halted_o[c] <= 1'b1;
    end

    p_start_runs_r10: assert property (@(posedge clk) disable iff (rst)
      (start_we && start_bits[c]) |=> !halted_o[c]);

    p_pdown_halts_r11: assert property (@(posedge clk) disable iff (rst)
      (pdown[c] && !(start_we && start_bits[c]) && !busy[c]) |=> halted_o[c]);
  end
endmodule

// File: rtl/mp_irq_ctrl.sv
`timescale 1ns/1ps
module mp_irq_ctrl
  import mp_irq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [15:0]          irq_req,
  input  logic [NCPU-1:0]      ack_valid,
  input  logic [4*NCPU-1:0]    ack_num,
  input  logic [NCPU-1:0]      pdown_req,
  output logic [4*NCPU-1:0]    cpu_level,
  output logic [NCPU-1:0]      cpu_run
);
  localparam logic MULTI = (NCPU > 1);

  irq_vec_t class_q, pend_q, bc_q;
  irq_vec_t mask_q  [NCPU];
  irq_vec_t force_q [NCPU];
  irq_vec_t class_n, pend_n, bc_n;
  irq_vec_t mask_n  [NCPU];
  irq_vec_t force_n [NCPU];

  logic [NLINE-1:0] rise_w;
  logic [NCPU-1:0]  halted, busy;
  logic [1:0]       win;
  logic [3:0]       idx;
  logic             aligned, wr, stat_we;
  irq_vec_t         wdat;
  logic             unused_hi;

  assign win     = bus_addr[7:6];
  assign idx     = bus_addr[5:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_sel && bus_wr && aligned;
  assign wdat    = bus_wdata[15:0] & LINE_MASK;
  assign stat_we = wr && (bus_addr == OFF_STAT);
  assign unused_hi = ^bus_wdata[31:16];

  mpirq_edge #(.W(NLINE)) u_edge (
    .clk(clk), .rst(rst), .lvl_in(irq_req), .rise_o(rise_w)
  );

  always_comb begin
    class_n = class_q;
    pend_n  = pend_q;
    bc_n    = bc_q;
    for (int c = 0; c < NCPU; c++) begin
      mask_n[c]  = mask_q[c];
      force_n[c] = force_q[c];
    end
    if (wr) begin
      if (bus_addr == OFF_CLASS) class_n = wdat;
      if (bus_addr == OFF_PEND)  pend_n  = wdat;
      if (bus_addr == OFF_CLR)   pend_n  = pend_n & ~wdat;
      if (bus_addr == OFF_BCAST) bc_n    = wdat;
      for (int c = 0; c < NCPU; c++) begin
        if (win == WIN_MASK  && idx == 4'(c)) mask_n[c]  = wdat;
        if (win == WIN_FORCE && idx == 4'(c)) force_n[c] = wdat;
      end
    end
    for (int c = 0; c < NCPU; c++) begin
      if (ack_valid[c]) begin
        if (force_n[c][ack_num[c*4 +: 4]]) force_n[c][ack_num[c*4 +: 4]] = 1'b0;
        else                               pend_n[ack_num[c*4 +: 4]]     = 1'b0;
      end
    end
    for (int n = 1; n < NLINE; n++) begin
      if (rise_w[n]) begin
        if (MULTI && bc_q[n]) begin
          for (int c = 0; c < NCPU; c++) force_n[c][n] = 1'b1;
        end else begin
          pend_n[n] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      class_q <= '0;
      pend_q  <= '0;
      bc_q    <= '0;
      for (int c = 0; c < NCPU; c++) begin
        mask_q[c]  <= '0;
        force_q[c] <= '0;
      end
    end else begin
      class_q <= class_n;
      pend_q  <= pend_n;
      bc_q    <= bc_n;
      for (int c = 0; c < NCPU; c++) begin
        mask_q[c]  <= mask_n[c];
        force_q[c] <= force_n[c];
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    mpirq_prio #(.W(NLINE), .LW(LVLW)) u_prio (
      .clk(clk), .rst(rst),
      .req((pend_q | force_q[c]) & mask_q[c]),
      .cls1(class_q),
      .lvl_o(cpu_level[c*4 +: 4])
    );
    assign busy[c] = (cpu_level[c*4 +: 4] != 4'd0);
  end

  mpirq_halt #(.NCPU(NCPU)) u_halt (
    .clk(clk), .rst(rst), .pdown(pdown_req), .start_we(stat_we),
    .start_bits(bus_wdata[NCPU-1:0]), .busy(busy), .halted_o(halted)
  );
  assign cpu_run = ~halted;

  logic [31:0] rd_mux, stat_w;
  assign stat_w = {4'(NCPU-1), MULTI, 7'd0, 4'd0, {(16-NCPU){1'b0}}, halted};

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_CLASS)      rd_mux = {16'h0, class_q};
    else if (bus_addr == OFF_PEND)  rd_mux = {16'h0, pend_q};
    else if (bus_addr == OFF_STAT)  rd_mux = stat_w;
    else if (bus_addr == OFF_BCAST) rd_mux = {16'h0, bc_q};
    for (int c = 0; c < NCPU; c++) begin
      if (aligned && win == WIN_MASK  && idx == 4'(c)) rd_mux = {16'h0, mask_q[c]};
      if (aligned && win == WIN_FORCE && idx == 4'(c)) rd_mux = {16'h0, force_q[c]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  p_class_bit0_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_addr == OFF_CLASS) |=> !class_q[0]);

  for (genvar n = 1; n < NLINE; n++) begin : g_chk
    p_rise_sets_r7: assert property (@(posedge clk) disable iff (rst)
      (rise_w[n] && !(MULTI && bc_q[n])) |=> pend_q[n]);
    p_bcast_force_r5: assert property (@(posedge clk) disable iff (rst)
      (rise_w[n] && MULTI && bc_q[n]) |=> force_q[0][n]);
  end
endmodule

// File: tb/mp_irq_ctrl_test.sv
`timescale 1ns/1ps
module mp_irq_ctrl_test;
  localparam int NCPU = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_req = '0;
  logic [NCPU-1:0] ack_valid = '0;
  logic [4*NCPU-1:0] ack_num = '0;
  logic [NCPU-1:0] pdown_req = '0;
  logic [4*NCPU-1:0] cpu_level;
  logic [NCPU-1:0] cpu_run;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_d = 1'b0;

  always #2.5 clk = ~clk;

  mp_irq_ctrl #(.NCPU(NCPU)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .ack_valid(ack_valid), .ack_num(ack_num), .pdown_req(pdown_req),
    .cpu_level(cpu_level), .cpu_run(cpu_run)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as registered read data arrives
  always @(posedge clk) rd_d <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    tick(1);
    bus_sel = 1'b0;
  endtask

  task automatic ack(input int c, input logic [3:0] n);
    ack_valid[c] = 1'b1; ack_num[c*4 +: 4] = n;
    tick(1);
    ack_valid[c] = 1'b0;
  endtask

  function automatic logic [31:0] lvl(input int c);
    return {28'h0, cpu_level[c*4 +: 4]};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL all: watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // reset state
    check("R11 reset run", {28'h0, cpu_run}, 32'h1);
    check("R3 reset level", {16'h0, cpu_level}, 32'h0);
    rd_chk(8'h10, 32'h3800000E, "R9 status after reset");

    wr_reg(8'h40, 32'hFFFE);
    wr_reg(8'h44, 32'h00F0);
    rd_chk(8'h44, 32'h00F0, "R12 mask1 readback");
    // precise output timing
    irq_req[5] = 1'b1;
    tick(1);
    check("R3 level not yet", lvl(0), 0);
    tick(1);
    check("R3 level after two edges", lvl(0), 5);
    check("R1 cpu1 masked in", lvl(1), 5);
    check("R1 cpu2 masked out", lvl(2), 0);
    tick(2);
    check("R11 nonzero level wakes cpu1", {28'h0, cpu_run}, 32'h3);

    irq_req[9] = 1'b1;
    tick(3);
    check("R3 highest wins cpu0", lvl(0), 9);
    check("R1 cpu1 lacks bit9", lvl(1), 5);

    wr_reg(8'h00, 32'h0021);
    rd_chk(8'h00, 32'h0020, "R8 class bit0 dropped");
    tick(2);
    check("R2 class-1 beats higher line", lvl(0), 5);

    ack(0, 4'd5);
    tick(3);
    rd_chk(8'h04, 32'h0200, "R4 held line not re-posted");
    check("R4 level after ack", lvl(0), 9);

    wr_reg(8'h80, 32'h0200);
    ack(0, 4'd9);
    rd_chk(8'h80, 32'h0000, "R6 force bit cleared first");
    rd_chk(8'h04, 32'h0200, "R6 pending kept");
    ack(0, 4'd9);
    rd_chk(8'h04, 32'h0000, "R6 pending cleared second");
    irq_req[5] = 1'b0; irq_req[9] = 1'b0;
    tick(2);

    wr_reg(8'h14, 32'h1000);
    irq_req[12] = 1'b1;
    tick(1);
    rd_chk(8'h04, 32'h0000, "R5 broadcast skips pending");
    rd_chk(8'h84, 32'h1000, "R5 force cpu1");
    rd_chk(8'h8C, 32'h1000, "R5 force cpu3");
    tick(2);
    check("R5 cpu0 sees broadcast", lvl(0), 12);
    ack(0, 4'd12);
    rd_chk(8'h84, 32'h1000, "R6 other cpu force kept");
    rd_chk(8'h80, 32'h0000, "R6 own force cleared");
    tick(2);
    check("R3 idle level zero", lvl(0), 0);
    irq_req[12] = 1'b0;

    irq_req[3] = 1'b1;
    tick(2);
    irq_req[3] = 1'b0;
    tick(2);
    irq_req[3] = 1'b1;
    ack(0, 4'd3);
    rd_chk(8'h04, 32'h0008, "R7 new edge beats ack");

    wr_reg(8'h0C, 32'h0008);
    rd_chk(8'h04, 32'h0000, "R8 clear write");
    rd_chk(8'h0C, 32'h0000, "R8 clear reads zero");
    rd_chk(8'hC0, 32'h0000, "R8 extended window zero");
    irq_req[3] = 1'b0;

    wr_reg(8'h10, 32'h0004);
    tick(1);
    check("R10 start cpu2", {28'h0, cpu_run}, 32'h7);
    rd_chk(8'h10, 32'h38000008, "R9 halted bits");
    wr_reg(8'h10, 32'h0008);
    pdown_req[3] = 1'b1;
    tick(1);
    pdown_req[3] = 1'b0;
    tick(1);
    check("R11 power-down halts cpu3", {28'h0, cpu_run}, 32'h7);
    wr_reg(8'h10, 32'h0000);
    tick(1);
    check("R10 zero write no effect", {28'h0, cpu_run}, 32'h7);
    rd_chk(8'h10, 32'h38000008, "R10 status unchanged");
    tick(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule